// File: doc/BRIEF.md
# Quad DAC serial update controller

This block is the digital front end for a four-channel, 12-bit serial voltage-output converter. A client makes a request on a valid/ready interface. An update request carries a channel number and a 12-bit code. A clear request carries a reset-level bit.

For an update, the block does the following:
- It lowers chip-select.
- It shifts a 16-bit word out most significant bit first. The serial clock idles high, and data changes on its falling edge.
- It strobes the load line low and then high, so the converter moves the word into the addressed channel's output register.
- It raises chip-select again.

For a clear, the block first sets the clear-level line and lets it settle. It then pulses the active-low clear line. With the level line low, the converter resets its outputs to zero scale; with it high, to mid scale.

A system-clock divider sets every serial timing interval. The ratio DIV is a parameter: it must be even and at least 2, and it defaults to 32. One serial clock period lasts DIV system clocks. Each wait in the sequence is a whole number of these periods: chip-select setup, hold before the load strobe, the load pulse itself, and hold before chip-select is released. The block takes one request at a time. It reports the end of each operation with a one-cycle done pulse.

Top module: `quad_dac_ctrl`

## Requirements
- R1: While reset is held and afterwards at idle, dac_cs_n, dac_ld_n, dac_clr_n and dac_sclk are 1, dac_sdi is 0, req_ready is 1 and done is 0; dac_clrsel resets to 1.
- R2: An update sends exactly 16 rising serial clock edges while dac_cs_n is low. The bits, first to last, are req_chan[1] and req_chan[0], then two 0 bits, then req_code[11] down to req_code[0]. The channel encoding is 0 = A, 1 = B, 2 = C, 3 = D.
- R3: dac_sclk stays 1 whenever dac_cs_n is 1. While dac_cs_n is low, dac_sdi changes only in the cycle in which dac_sclk falls, so it is stable at every rising edge.
- R4: The first falling edge of dac_sclk comes exactly DIV system clocks after dac_cs_n falls. Each low phase and each high phase of dac_sclk within a frame lasts DIV/2 system clocks. DIV defaults to 32.
- R5: After the 16th rising edge, with dac_cs_n still low, dac_ld_n goes low for exactly DIV clocks. Its fall comes at least DIV clocks after the last rising edge. dac_cs_n rises exactly DIV clocks after dac_ld_n rises.
- R6: A clear request (req_clear=1) lowers dac_clr_n exactly DIV clocks after acceptance and holds it low for exactly DIV clocks. dac_cs_n and dac_ld_n stay 1 and dac_sclk does not toggle.
- R7: On acceptance of a clear, dac_clrsel takes req_mid (0 = zero scale, 1 = mid scale). It holds that value, unchanged through the clear pulse, until the next clear is accepted.
- R8: A request is accepted only at idle. req_ready is 0 from acceptance until dac_cs_n rises (update) or dac_clr_n rises (clear). A request raised and dropped while busy has no effect.
- R9: done is high for exactly one clock. It rises in the cycle dac_cs_n rises, 20*DIV clocks after dac_cs_n fell, or in the cycle dac_clr_n rises, 2*DIV clocks after the clear was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_clear | input | 1 | 1 = clear request, 0 = update request |
| req_mid | input | 1 | Clear level: 0 zero scale, 1 mid scale |
| req_chan | input | 2 | Target channel, 0..3 = A..D |
| req_code | input | 12 | Output code for the update |
| done | output | 1 | One-cycle completion pulse |
| dac_cs_n | output | 1 | Converter chip-select, active low |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdi | output | 1 | Serial data, most significant bit first |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear line, active low |
| dac_clrsel | output | 1 | Clear reset level select |

## Verification
The bench sweeps all four channels with codes that include all-zeros, all-ones and a spread of mixed patterns, and rebuilds each frame from the edges it observes. A wrong address position or wrong pad bits shows up as a mismatched word. An extra shift after the last bit moves dac_sdi while the clock is high, and the bench catches that. It also measures every serial interval against DIV. A divider with a slip of one cycle, or a load strobe placed before the last edge or after chip-select has risen, gives a measured count that disagrees with the requirement. Clears at both levels check that dac_clrsel is latched before the pulse and held after it. A clear request raised and dropped in the middle of an update must not start a second operation: an accept path that does not check for idle would produce a clear pulse or a second done.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SHIFT,
      ST_HOLD,
      ST_LOAD,
      ST_LREL,
      ST_CSET,
      ST_CLR
   } qdc_state_e;
endpackage

// File: rtl/qdc_divider.sv
module qdc_divider #(
   parameter int DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic slot_end,
   output logic low_half
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
   localparam logic [CW-1:0] HALFV = CW'(DIV / 2);

   if ((DIV < 2) || ((DIV % 2) != 0)) begin : g_bad_div
      $error("qdc_divider: DIV must be even and at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || (cnt == LAST))
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign slot_end = run && (cnt == LAST);
   assign low_half = (cnt < HALFV);

   // R4
   idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run && $past(!run) |-> (cnt == '0));
endmodule

// File: rtl/qdc_shifter.sv
module qdc_shifter #(
   parameter int ADDR_W = 2,
   parameter int PAD_W  = 2,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [ADDR_W-1:0] chan,
   input  logic [DATA_W-1:0] code,
   output logic              msb
);
   localparam int FRAME_W = ADDR_W + PAD_W + DATA_W;

   if ((ADDR_W < 1) || (PAD_W < 0) || (DATA_W < 1)) begin : g_bad_fmt
      $error("qdc_shifter: invalid frame field widths");
   end

   logic [FRAME_W-1:0] frame;
   logic [FRAME_W-1:0] frame_new;

   if (PAD_W > 0) begin : g_pad
      assign frame_new = {chan, {PAD_W{1'b0}}, code};
   end else begin : g_nopad
      assign frame_new = {chan, code};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame <= '0;
      else if (load)
         frame <= frame_new;
      else if (shift)
         frame <= {frame[FRAME_W-2:0], 1'b0};
   end

   assign msb = frame[FRAME_W-1];

   // R2
   no_load_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
   import qdc_pkg::*;
#(
   parameter int DIV    = 32,
   parameter int ADDR_W = 2,
   parameter int PAD_W  = 2,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_clear,
   input  logic              req_mid,
   input  logic [ADDR_W-1:0] req_chan,
   input  logic [DATA_W-1:0] req_code,
   output logic              done,
   output logic              dac_cs_n,
   output logic              dac_sclk,
   output logic              dac_sdi,
   output logic              dac_ld_n,
   output logic              dac_clr_n,
   output logic              dac_clrsel
);
   localparam int FRAME_W = ADDR_W + PAD_W + DATA_W;
   localparam int BW      = $clog2(FRAME_W);
   localparam logic [BW-1:0] LASTBIT = BW'(FRAME_W - 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("quad_dac_ctrl: frame must hold at least two bits");
   end

   qdc_state_e    state;
   logic [BW-1:0] bitcnt;
   logic          clrsel_q;
   logic          done_q;
   logic          accept;
   logic          run;
   logic          slot_end;
   logic          low_half;
   logic          shift_en;
   logic          load_en;
   logic          msb;
   logic          in_frame;

   assign accept   = req_valid && (state == ST_IDLE);
   assign run      = (state != ST_IDLE);
   assign load_en  = accept && !req_clear;
   assign shift_en = slot_end && (state == ST_SHIFT) && (bitcnt != LASTBIT);

   qdc_divider #(.DIV(DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .slot_end (slot_end),
      .low_half (low_half)
   );

   qdc_shifter #(.ADDR_W(ADDR_W), .PAD_W(PAD_W), .DATA_W(DATA_W)) u_shf (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_en),
      .shift (shift_en),
      .chan  (req_chan),
      .code  (req_code),
      .msb   (msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         clrsel_q <= 1'b1;
         done_q   <= 1'b0;
      end else begin
         done_q <= slot_end && ((state == ST_LREL) || (state == ST_CLR));
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (req_clear) begin
                     state    <= ST_CSET;
                     clrsel_q <= req_mid;
                  end else begin
                     state <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: if (slot_end) begin
               state  <= ST_SHIFT;
               bitcnt <= '0;
            end
            ST_SHIFT: if (slot_end) begin
               if (bitcnt == LASTBIT)
                  state <= ST_HOLD;
               else
                  bitcnt <= bitcnt + 1'b1;
            end
            ST_HOLD: if (slot_end) state <= ST_LOAD;
            ST_LOAD: if (slot_end) state <= ST_LREL;
            ST_LREL: if (slot_end) state <= ST_IDLE;
            ST_CSET: if (slot_end) state <= ST_CLR;
            ST_CLR:  if (slot_end) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_frame   = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_HOLD) ||
                       (state == ST_LOAD) || (state == ST_LREL);
   assign req_ready  = (state == ST_IDLE);
   assign dac_cs_n   = !in_frame;
   assign dac_ld_n   = (state != ST_LOAD);
   assign dac_clr_n  = (state != ST_CLR);
   assign dac_sclk   = !((state == ST_SHIFT) && low_half);
   assign dac_sdi    = in_frame && msb;
   assign dac_clrsel = clrsel_q;
   assign done       = done_q;

   // R5
   ld_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_ld_n |-> !dac_cs_n);
   // R3
   sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_cs_n |-> dac_sclk);
   // R3
   sdi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_cs_n && $past(!dac_cs_n) && !$stable(dac_sdi)) |-> $fell(dac_sclk));
   // R6
   clr_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_clr_n |-> (dac_cs_n && dac_ld_n && dac_sclk));
   // R7
   clrsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_clr_n |-> $stable(dac_clrsel));
   // R8
   ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_cs_n || !dac_clr_n) |-> !req_ready);
   // R9
   done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($rose(dac_cs_n) || $rose(dac_clr_n)));
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/test_quad_dac_ctrl.sv
module test_quad_dac_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 32;
   localparam int H   = DIV / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_clear = 1'b0, req_mid = 1'b0;
   logic [1:0]  req_chan = '0;
   logic [11:0] req_code = '0;
   logic req_ready, done, dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, dac_clr_n, dac_clrsel;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_dac_ctrl i_quad_dac_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_clear(req_clear), .req_mid(req_mid), .req_chan(req_chan), .req_code(req_code),
      .done(done), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
      .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n), .dac_clrsel(dac_clrsel)
   );

   // monitor state, updated only at negative edges, read by tasks at positive edges
   int cyc = 0;
   logic p_cs = 1, p_sclk = 1, p_sdi = 0, p_ld = 1, p_clr = 1, p_done = 0, p_rdy = 1, p_sel = 1;
   int t_csf, t_ff, t_edge, t_lr, t_ldf, t_ldr, t_csr, t_clrf, t_clrr, t_rdyf;
   int nfalls, rises, rises_at_ld, sdi_bad, width_bad, idle_sclk_bad, rdy_bad, sel_bad;
   int ndone = 0, done_long = 0, clrfalls = 0;
   logic [15:0] shreg, frame_at_ld;
   logic cs_at_ld, done_at_csr, done_at_clrr, sel_at_clr, cs_at_clr;

   initial begin
      sdi_bad = 0; width_bad = 0; idle_sclk_bad = 0; rdy_bad = 0; sel_bad = 0;
      nfalls = 0; rises = 0; shreg = '0;
   end

   always @(negedge clk) begin
      cyc++;
      if (p_rdy && !req_ready) t_rdyf = cyc;
      if (p_cs && !dac_cs_n) begin
         t_csf = cyc; t_edge = cyc; nfalls = 0; rises = 0; shreg = '0;
      end
      if (!dac_cs_n && !p_cs) begin
         if (p_sclk && !dac_sclk) begin
            if (nfalls == 0) t_ff = cyc;
            else if (cyc - t_edge != H) width_bad++;
            nfalls++; t_edge = cyc;
         end
         if (!p_sclk && dac_sclk) begin
            shreg = {shreg[14:0], dac_sdi}; rises++;
            if (cyc - t_edge != H) width_bad++;
            t_edge = cyc; t_lr = cyc;
         end
         if ((dac_sdi != p_sdi) && !(p_sclk && !dac_sclk)) sdi_bad++;
      end
      if (dac_cs_n && !dac_sclk) idle_sclk_bad++;
      if (!dac_cs_n && req_ready) rdy_bad++;
      if (p_ld && !dac_ld_n) begin
         t_ldf = cyc; frame_at_ld = shreg; rises_at_ld = rises; cs_at_ld = dac_cs_n;
      end
      if (!p_ld && dac_ld_n) t_ldr = cyc;
      if (!p_cs && dac_cs_n) begin t_csr = cyc; done_at_csr = done; end
      if (p_clr && !dac_clr_n) begin
         t_clrf = cyc; clrfalls++; sel_at_clr = dac_clrsel; cs_at_clr = dac_cs_n;
      end
      if (!dac_clr_n && (dac_clrsel != p_sel)) sel_bad++;
      if (!p_clr && dac_clr_n) begin t_clrr = cyc; done_at_clrr = done; end
      if (done) begin ndone++; if (p_done) done_long++; end
      p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdi = dac_sdi; p_ld = dac_ld_n;
      p_clr = dac_clr_n; p_done = done; p_rdy = req_ready; p_sel = dac_clrsel;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic start_req(input logic clr, input logic mid, input logic [1:0] ch,
                            input logic [11:0] code);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_clear = clr; req_mid = mid; req_chan = ch; req_code = code;
      @(negedge clk);
      req_valid = 1'b0; req_clear = 1'b0;
   endtask

   task automatic wait_done(input int n0);
      int guard = 0;
      while ((ndone <= n0) && (guard < 4 * 20 * DIV)) begin
         @(posedge clk); guard++;
      end
      @(posedge clk);
   endtask

   task automatic check_update(input logic [1:0] ch, input logic [11:0] code);
      logic [15:0] exp_frame;
      exp_frame = {ch, 2'b00, code};
      chk(frame_at_ld == exp_frame, "R2 frame", int'(frame_at_ld), int'(exp_frame));
      chk(rises_at_ld == 16, "R2 rising edges before load", rises_at_ld, 16);
      chk(sdi_bad == 0, "R3 sdi moved away from falling edge", sdi_bad, 0);
      chk(t_ff - t_csf == DIV, "R4 cs setup", t_ff - t_csf, DIV);
      chk(width_bad == 0, "R4 sclk phase widths", width_bad, 0);
      chk(t_ldr - t_ldf == DIV, "R5 load width", t_ldr - t_ldf, DIV);
      chk(t_ldf - t_lr >= DIV, "R5 last edge to load", t_ldf - t_lr, DIV);
      chk(cs_at_ld == 1'b0, "R5 cs low at load", int'(cs_at_ld), 0);
      chk(t_csr - t_ldr == DIV, "R5 load to cs release", t_csr - t_ldr, DIV);
      chk(t_csr - t_csf == 20 * DIV, "R9 update latency", t_csr - t_csf, 20 * DIV);
      chk(done_at_csr == 1'b1, "R9 done at cs release", int'(done_at_csr), 1);
   endtask

   task automatic do_clear(input logic mid);
      int n0, f0;
      n0 = ndone; f0 = clrfalls;
      start_req(1'b1, mid, 2'd0, 12'd0);
      wait_done(n0);
      chk(clrfalls == f0 + 1, "R6 one clear pulse", clrfalls, f0 + 1);
      chk(t_clrf - t_rdyf == DIV, "R6 clear delay", t_clrf - t_rdyf, DIV);
      chk(t_clrr - t_clrf == DIV, "R6 clear width", t_clrr - t_clrf, DIV);
      chk(cs_at_clr == 1'b1, "R6 cs high during clear", int'(cs_at_clr), 1);
      chk(sel_at_clr == mid, "R7 level during clear", int'(sel_at_clr), int'(mid));
      chk(sel_bad == 0, "R7 level stable in pulse", sel_bad, 0);
      chk(done_at_clrr == 1'b1, "R9 done at clear end", int'(done_at_clrr), 1);
      chk(t_clrr - t_rdyf == 2 * DIV, "R9 clear latency", t_clrr - t_rdyf, 2 * DIV);
      repeat (3 * DIV) @(posedge clk);
      chk(dac_clrsel == mid, "R7 level held after clear", int'(dac_clrsel), int'(mid));
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(dac_cs_n && dac_ld_n && dac_clr_n && dac_sclk, "R1 control lines in reset",
          int'({dac_cs_n, dac_ld_n, dac_clr_n, dac_sclk}), 15);
      chk(!dac_sdi && !done, "R1 sdi and done in reset", int'({dac_sdi, done}), 0);
      chk(dac_clrsel == 1'b1, "R1 clrsel reset level", int'(dac_clrsel), 1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready at idle", int'(req_ready), 1);
      chk(dac_cs_n && dac_sclk && !dac_sdi, "R1 idle after reset",
          int'({dac_cs_n, dac_sclk, dac_sdi}), 6);

      for (int ch = 0; ch < 4; ch++) begin
         for (int k = 0; k < 18; k++) begin
            logic [11:0] code;
            int n0;
            if (k == 0)       code = 12'h000;
            else if (k == 17) code = 12'hFFF;
            else              code = 12'((k * 32'h2A7 + ch * 32'h13 + (1 << (k % 12))) & 32'hFFF);
            n0 = ndone;
            start_req(1'b0, 1'b0, 2'(ch), code);
            wait_done(n0);
            check_update(2'(ch), code);
            chk(ndone == n0 + 1, "R9 one done per update", ndone, n0 + 1);
         end
      end

      do_clear(1'b0);
      do_clear(1'b1);
      do_clear(1'b0);

      begin
         int n0, f0;
         n0 = ndone; f0 = clrfalls;
         start_req(1'b0, 1'b0, 2'd2, 12'hA5C);
         repeat (100) @(negedge clk);
         req_valid = 1'b1; req_clear = 1'b1; req_mid = 1'b1;
         repeat (5) @(negedge clk);
         req_valid = 1'b0; req_clear = 1'b0;
         wait_done(n0);
         check_update(2'd2, 12'hA5C);
         repeat (4 * DIV) @(posedge clk);
         chk(clrfalls == f0, "R8 busy request ignored, no clear", clrfalls, f0);
         chk(ndone == n0 + 1, "R8 busy request ignored, one done", ndone, n0 + 1);
         chk(dac_cs_n == 1'b1 && req_ready == 1'b1, "R8 idle after busy request",
             int'({dac_cs_n, req_ready}), 3);
         chk(dac_clrsel == 1'b0, "R8 level not taken while busy", int'(dac_clrsel), 0);
      end

      chk(rdy_bad == 0, "R8 ready low while busy", rdy_bad, 0);
      chk(idle_sclk_bad == 0, "R3 sclk idles high", idle_sclk_bad, 0);
      chk(done_long == 0, "R9 done one cycle", done_long, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule